// File: doc/BRIEF.md
# Hall-Driven Six-Step Commutation Decoder

This block drives the six gate commands of a three-phase half-bridge stage from one PWM signal and a 3-bit rotor position code. The position code may come from a controller or straight from the motor's digital hall sensors. Each valid code names one phase that is chopped by the PWM and one phase that sinks current; the third phase floats. A direction input turns the motor the other way by selecting each drive pattern with the complement of its forward code. Two more codes exist: one that stops the bridge and one that parks the rotor for alignment. An active-low brake input overrides everything else and shorts the windings through the low-side switches.

The position bits, the direction input and the brake input are asynchronous, so each passes through a two-flop synchronizer before it is decoded. The PWM and the rectification-mode bit are treated as synchronous to the clock. The rectification mode sets what the chopped phase does in its PWM-off time. In synchronous mode its low side switches on. In asynchronous mode both switches stay off, so current freewheels through the body diode. A dead time of `DEAD_CYC` clock cycles keeps the two switches of a phase from conducting together. When the drive pattern changes, every switch that leaves the pattern is turned off for the whole dead time before any new switch is turned on.

Top module: `sixstep_commutator`

## Requirements
- R1: With the direction input at 0, position code {A,B,C} selects the PWM phase and sink phase as follows: 100 → A/C, 101 → A/B, 110 → B/C, 010 → B/A, 011 → C/A, 001 → C/B. The sink phase holds its low side on and its high side off. The remaining phase has both switches off. Output bit 0 is phase A, bit 1 is B and bit 2 is C.
- R2: With the direction input at 1, each of those six patterns is chosen by the bitwise complement of its direction-0 code. For example, 001 selects B/C and 101 selects B/A.
- R3: Code 000 is a stop state for either direction, and all six gate outputs are low.
- R4: Code 111 is an align state for either direction. Phase A is the PWM phase, and the low sides of B and C are held on.
- R5: In synchronous mode (`async_mode` = 0), the PWM phase drives its high side equal to the PWM and its low side equal to the inverted PWM, apart from dead-time gaps.
- R6: In asynchronous mode (`async_mode` = 1), the PWM phase drives its high side equal to the PWM and keeps its low side off.
- R7: While `brake_n` is low, once the change has settled, all high-side outputs are low and all low-side outputs are high, whatever the other inputs are.
- R8: After reset, all six outputs stay low for at least the two cycles the synchronizers need before their outputs are valid.
- R9: The high-side and low-side outputs of a phase are never both high.
- R10: A switch turns on only after the opposite switch of its phase has been off for at least `DEAD_CYC` cycles (default 4). On a PWM edge the gap is exactly `DEAD_CYC` cycles.
- R11: A change of the synchronized position code is decoded on the third clock edge after the input moves. Outgoing switches turn off on the next edge, and incoming switches turn on `DEAD_CYC` edges after that. A switch present in both patterns is not interrupted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM, synchronous to clk |
| hall_in | input | 3 | Position code, bit 2 = A, bit 1 = B, bit 0 = C (asynchronous) |
| dir_in | input | 1 | Direction select (asynchronous) |
| brake_n | input | 1 | Active-low brake (asynchronous) |
| async_mode | input | 1 | 1 = diode freewheel, 0 = complementary chopping |
| gate_hi | output | 3 | High-side gate commands, bit 0 = A |
| gate_lo | output | 3 | Low-side gate commands, bit 0 = A |

## Verification
The bench steps through every code for both directions, both rectification modes and both PWM levels. A design that failed to complement the code for reverse, or that complemented the stop and align codes too, would drive the wrong phase pair. It measures the both-off gap of a phase across PWM edges, where a counter off by one would shorten the gap or make both switches conduct together. It also times a commutation step edge by edge: a design that switched in the incoming phase together with the outgoing one, or that briefly dropped the shared sink switch, shows up at a specific sample. The bench also holds brake asserted through reset, which exposes any output that goes high before the synchronizers are valid.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

  localparam int NPH = 3;

  typedef logic [1:0] drv_t;
  localparam drv_t DRV_OFF  = 2'd0;
  localparam drv_t DRV_PWM  = 2'd1;
  localparam drv_t DRV_SINK = 2'd2;

  typedef drv_t [NPH-1:0] pat_t;

  // one chopped phase, one sinking phase, the rest floating
  function automatic pat_t pair_pat(int src, int snk);
    pat_t p;
    p = {NPH{DRV_OFF}};
    p[src] = DRV_PWM;
    p[snk] = DRV_SINK;
    return p;
  endfunction

  // code bit 2 = phase A, bit 1 = B, bit 0 = C
  function automatic pat_t decode_state(logic [2:0] code, logic rev, logic brake);
    pat_t p;
    logic [2:0] c;
    p = {NPH{DRV_OFF}};
    c = rev ? ~code : code;
    if (brake) begin
      p = {NPH{DRV_SINK}};
    end else if (code == 3'b111) begin
      p[0] = DRV_PWM;
      p[1] = DRV_SINK;
      p[2] = DRV_SINK;
    end else if (code != 3'b000) begin
      case (c)
        3'b110:  p = pair_pat(1, 2);
        3'b100:  p = pair_pat(0, 2);
        3'b101:  p = pair_pat(0, 1);
        3'b001:  p = pair_pat(2, 1);
        3'b011:  p = pair_pat(2, 0);
        3'b010:  p = pair_pat(1, 0);
        default: p = {NPH{DRV_OFF}};
      endcase
    end
    return p;
  endfunction

  // returns {want_hi, want_lo} for one phase
  function automatic logic [1:0] gate_req(drv_t d, logic pwm, logic freewheel);
    logic [1:0] r;
    case (d)
      DRV_PWM:  r = {pwm, ~pwm & ~freewheel};
      DRV_SINK: r = 2'b01;
      default:  r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sixstep_sync.sv
module sixstep_sync #(
  parameter int              WIDTH   = 5,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             valid
);

  logic [WIDTH-1:0] meta_q, stab_q;
  logic [1:0]       fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
      fill_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
      fill_q <= {fill_q[0], 1'b1};
    end
  end

  assign q     = stab_q;
  assign valid = fill_q[1];

endmodule

// File: rtl/sixstep_seq.sv
module sixstep_seq
  import sixstep_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  pat_t want,
  output pat_t drive,
  output logic busy
);

  localparam int              CW   = (DEAD_CYC > 2) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0]   LAST = CW'(DEAD_CYC - 1);

  pat_t          applied_q, target_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied_q <= {NPH{DRV_OFF}};
      target_q  <= {NPH{DRV_OFF}};
      cnt_q     <= '0;
      busy_q    <= 1'b0;
    end else if (!busy_q) begin
      if (want != applied_q) begin
        busy_q   <= 1'b1;
        target_q <= want;
        cnt_q    <= '0;
      end
    end else if (want != target_q) begin
      target_q <= want;
      cnt_q    <= '0;
    end else if (cnt_q == LAST) begin
      applied_q <= target_q;
      busy_q    <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // while blanking, only phases common to old and new pattern keep driving
  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      drive[p] = (!busy_q || applied_q[p] == target_q[p]) ? applied_q[p] : DRV_OFF;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/sixstep_gate.sv
module sixstep_gate #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hi,
  input  logic want_lo,
  output logic gh,
  output logic gl
);

  localparam int            CW   = (DEAD_CYC > 2) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

  logic [CW-1:0] hi_idle_q, lo_idle_q;
  logic          hi_ok, lo_ok;

  assign hi_ok = want_hi & ~gl & (lo_idle_q == LAST);
  assign lo_ok = want_lo & ~want_hi & ~gh & (hi_idle_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gh        <= 1'b0;
      gl        <= 1'b0;
      hi_idle_q <= LAST;
      lo_idle_q <= LAST;
    end else begin
      gh        <= hi_ok;
      gl        <= lo_ok;
      hi_idle_q <= gh ? '0 : ((hi_idle_q == LAST) ? LAST : hi_idle_q + 1'b1);
      lo_idle_q <= gl ? '0 : ((lo_idle_q == LAST) ? LAST : lo_idle_q + 1'b1);
    end
  end

endmodule

// File: rtl/sixstep_commutator.sv
module sixstep_commutator
  import sixstep_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in,
  input  logic [2:0] hall_in,
  input  logic       dir_in,
  input  logic       brake_n,
  input  logic       async_mode,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo
);

  localparam int SYW = 5;

  logic [SYW-1:0] synced;
  logic           inputs_valid;
  logic [2:0]     hall_s;
  logic           dir_s, brake_n_s, brake_on, blanking;
  pat_t           want, drive;

  sixstep_sync #(
    .WIDTH  (SYW),
    .RST_VAL(5'b10000)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({brake_n, dir_in, hall_in}),
    .q    (synced),
    .valid(inputs_valid)
  );

  assign hall_s    = synced[2:0];
  assign dir_s     = synced[3];
  assign brake_n_s = synced[4];
  assign brake_on  = inputs_valid & ~brake_n_s;

  assign want = inputs_valid ? decode_state(hall_s, dir_s, brake_on) : {NPH{DRV_OFF}};

  sixstep_seq #(
    .DEAD_CYC(DEAD_CYC)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .want (want),
    .drive(drive),
    .busy (blanking)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [1:0] req;
    assign req = gate_req(drive[p], pwm_in, async_mode);
    sixstep_gate #(
      .DEAD_CYC(DEAD_CYC)
    ) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .want_hi(req[1]),
      .want_lo(req[0]),
      .gh     (gate_hi[p]),
      .gl     (gate_lo[p])
    );
  end

endmodule

// File: rtl/sixstep_commutator_chk.sv
module sixstep_commutator_chk #(
  parameter int DEAD_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo,
  input logic       brake_on,
  input logic       inputs_valid
);

  localparam int SAT = DEAD_CYC + 16;

  int brake_run;
  int hi_off [3];
  int lo_off [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brake_run <= 0;
      for (int p = 0; p < 3; p++) begin
        hi_off[p] <= DEAD_CYC;
        lo_off[p] <= DEAD_CYC;
      end
    end else begin
      brake_run <= brake_on ? ((brake_run < SAT) ? brake_run + 1 : brake_run) : 0;
      for (int p = 0; p < 3; p++) begin
        hi_off[p] <= gate_hi[p] ? 0 : ((hi_off[p] < SAT) ? hi_off[p] + 1 : hi_off[p]);
        lo_off[p] <= gate_lo[p] ? 0 : ((lo_off[p] < SAT) ? lo_off[p] + 1 : lo_off[p]);
      end
    end
  end

  // R9
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == 3'b000);

  // R8
  quiet_until_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inputs_valid |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  // R7
  brake_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_run >= DEAD_CYC + 2) |-> (gate_hi == 3'b000 && gate_lo == 3'b111));

  for (genvar p = 0; p < 3; p++) begin : g_dt
    // R10
    hi_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[p]) |-> (lo_off[p] >= DEAD_CYC));
    // R10
    lo_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[p]) |-> (hi_off[p] >= DEAD_CYC));
  end

endmodule

bind sixstep_commutator sixstep_commutator_chk #(
  .DEAD_CYC(DEAD_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_hi     (gate_hi),
  .gate_lo     (gate_lo),
  .brake_on    (brake_on),
  .inputs_valid(inputs_valid)
);

// File: tb/sixstep_commutator_bench.sv
`timescale 1ns/1ps
module sixstep_commutator_bench;

  localparam int DEAD = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwm_in;
  logic [2:0] hall_in;
  logic       dir_in;
  logic       brake_n;
  logic       async_mode;
  logic [2:0] gate_hi, gate_lo;

  always #2 clk = ~clk;

  sixstep_commutator #(.DEAD_CYC(DEAD)) u_sixstep_commutator (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .hall_in(hall_in),
    .dir_in(dir_in), .brake_n(brake_n), .async_mode(async_mode),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected {hi[2:0], lo[2:0]}, written from the source/sink view
  function automatic logic [5:0] model(logic [2:0] code, logic dir, logic brk_n,
                                       logic asy, logic pwm);
    logic [2:0] hi, lo, k;
    int src, snk;
    hi = 3'b000; lo = 3'b000; src = 0; snk = 1;
    if (!brk_n) return {3'b000, 3'b111};
    if (code == 3'b000) return 6'b0;
    if (code == 3'b111) begin
      hi[0] = pwm;
      lo    = 3'b110;
      lo[0] = !asy && !pwm;
      return {hi, lo};
    end
    k = dir ? ~code : code;
    case (k)
      3'b100: begin src = 0; snk = 2; end
      3'b101: begin src = 0; snk = 1; end
      3'b110: begin src = 1; snk = 2; end
      3'b010: begin src = 1; snk = 0; end
      3'b011: begin src = 2; snk = 0; end
      default: begin src = 2; snk = 1; end
    endcase
    hi[src] = pwm;
    lo[snk] = 1'b1;
    lo[src] = !asy && !pwm;
    return {hi, lo};
  endfunction

  function automatic string tag_for(int c, int d, int a);
    string s;
    if (c == 0)      s = "R3";
    else if (c == 7) s = "R4";
    else             s = d ? "R2" : "R1";
    return {s, a ? "+R6" : "+R5"};
  endfunction

  // driver: apply, settle, push expectation for the monitor
  task automatic drive_and_expect(logic [2:0] code, logic dir, logic brk_n,
                                  logic asy, logic pwm, string tag);
    item_t it;
    @(negedge clk);
    hall_in = code; dir_in = dir; brake_n = brk_n; async_mode = asy; pwm_in = pwm;
    repeat (DEAD + 8) @(posedge clk);
    it.exp = model(code, dir, brk_n, asy, pwm);
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare against the scoreboard away from the active edge
  always @(negedge clk) begin : mon
    item_t it;
    if (sb_q.size() != 0) begin
      it = sb_q.pop_front();
      chk({gate_hi, gate_lo} == it.exp, it.tag, {26'd0, gate_hi, gate_lo}, {26'd0, it.exp});
    end
  end

  // gap monitor: both-off run between opposite switches of each phase
  int both_off [3];
  int last_on  [3];
  int last_gap [3];
  always @(negedge clk) begin : gapmon
    int now;
    if (rst_n) begin
      for (int p = 0; p < 3; p++) begin
        if (gate_hi[p] && gate_lo[p]) begin
          chk(1'b0, "R9 both switches on", 32'd3, 32'd0);
        end else if (gate_hi[p] || gate_lo[p]) begin
          now = gate_hi[p] ? 1 : 2;
          if (last_on[p] != 0 && last_on[p] != now) begin
            last_gap[p] = both_off[p];
            chk(both_off[p] >= DEAD, "R10 gap too short", both_off[p], DEAD);
          end
          last_on[p]  = now;
          both_off[p] = 0;
        end else begin
          both_off[p]++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 3; p++) begin
      both_off[p] = 0; last_on[p] = 0; last_gap[p] = 0;
    end
    rst_n = 1'b0; pwm_in = 1'b1; hall_in = 3'b000; dir_in = 1'b0;
    brake_n = 1'b0; async_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: outputs stay low while the synchronizers fill, even with brake held
    @(negedge clk);
    chk({gate_hi, gate_lo} == 6'd0, "R8 after edge 1", {26'd0, gate_hi, gate_lo}, 0);
    @(negedge clk);
    chk({gate_hi, gate_lo} == 6'd0, "R8 after edge 2", {26'd0, gate_hi, gate_lo}, 0);

    // R7: brake settles to all low sides
    drive_and_expect(3'b000, 1'b0, 1'b0, 1'b0, 1'b1, "R7 brake from reset");

    // R1..R6: full table
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 2; a++)
        for (int w = 0; w < 2; w++)
          for (int c = 0; c < 8; c++)
            drive_and_expect(3'(c), d[0], 1'b1, a[0], w[0], tag_for(c, d, a));

    // R7: brake beats every other input
    drive_and_expect(3'b101, 1'b0, 1'b0, 1'b0, 1'b1, "R7 brake over code");
    drive_and_expect(3'b111, 1'b1, 1'b0, 1'b1, 1'b0, "R7 brake over align");
    drive_and_expect(3'b011, 1'b1, 1'b0, 1'b0, 1'b1, "R7 brake reverse");
    drive_and_expect(3'b011, 1'b1, 1'b1, 1'b0, 1'b1, "R2 after brake exit");

    // R10: exact gap on PWM edges, phase A chopped in synchronous mode
    drive_and_expect(3'b100, 1'b0, 1'b1, 1'b0, 1'b1, "R1 setup A/C");
    @(negedge clk);
    pwm_in = 1'b0;
    repeat (DEAD + 4) @(negedge clk);
    chk(last_gap[0] == DEAD, "R10 gap on PWM fall", last_gap[0], DEAD);
    chk(gate_lo[0] == 1'b1, "R5 low side after PWM fall", gate_lo[0], 1);
    pwm_in = 1'b1;
    repeat (DEAD + 4) @(negedge clk);
    chk(last_gap[0] == DEAD, "R10 gap on PWM rise", last_gap[0], DEAD);
    chk(gate_hi[0] == 1'b1, "R5 high side after PWM rise", gate_hi[0], 1);

    // R11: commutation A/C -> B/C, sink C uninterrupted
    hall_in = 3'b110;
    for (int i = 1; i <= DEAD + 5; i++) begin
      @(negedge clk);
      chk(gate_lo == 3'b100, $sformatf("R11 sink held edge %0d", i), gate_lo, 3'b100);
      if (i == 3)
        chk(gate_hi == 3'b001, "R11 old pattern before decode", gate_hi, 3'b001);
      if (i == 4)
        chk(gate_hi == 3'b000, "R11 outgoing off", gate_hi, 3'b000);
      if (i == DEAD + 3)
        chk(gate_hi == 3'b000, "R11 incoming still blanked", gate_hi, 3'b000);
      if (i == DEAD + 4)
        chk(gate_hi == 3'b010, "R11 incoming on", gate_hi, 3'b010);
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule